// File: doc/BRIEF.md
# Flash Power and Block-Protection State Controller

This block holds the control state of a NOR-style flash die apart from its array. From the chip-enable, latch-enable and hardware-reset pins it derives the operating mode, which is one of reset, standby, active or deep power-down. It decides when read data may be trusted, and it keeps a lock state for every erase block. Two configuration bits govern deep power-down: one permits entry, and one picks the polarity of the power-down pin. A program/erase start is accepted only when the program-voltage flag is good at that instant.

A command decoder drives the one-cycle lock, unlock, lock-down, sync-read and operation requests. The datapath uses `data_valid` to gate its output drivers, and it reads `lock_state` to refuse writes to protected blocks. All pins are sampled on the rising edge of `clk`, and every output is registered, so a pin change shows at the outputs one cycle later.

Top module: `flash_pwr_prot_ctrl`

## Requirements
- R1: While `rst_pin_n` is 0, the next cycle shows `mode` = 0 (reset, codes: 0 reset, 1 standby, 2 active, 3 deep power-down), and `data_valid` is 0.
- R2: A cycle with `rst_pin_n` = 0, or the system reset, sets every block to locked (code 1), clears `op_busy` and returns `read_sync` to 0 (asynchronous read).
- R3: `data_valid` is 1 only in active mode, and only once a 1-to-0 transition of `ce_n` or `le_n` has been sampled since the reset pin was last low.
- R4: With `rst_pin_n` = 1 and outside deep power-down, `ce_n` = 1 gives standby and `ce_n` = 0 gives active on the next cycle.
- R5: Deep power-down (3) is entered only from standby, with `cfg_dpd_en` = 1 and the pin asserted. With `cfg_dpd_en` = 0 the pin has no effect.
- R6: The pin is asserted when `dpd_pin` equals `cfg_dpd_pol`: polarity 0 means active low (the default), and polarity 1 means active high.
- R7: In deep power-down the mode holds whatever `ce_n` does until the pin is deasserted. The device then returns to standby.
- R8: Lock codes are 0 unlocked, 1 locked and 2 locked-down. A request acts on block `blk_idx` on the next cycle. When several request bits are set, lock-down wins over lock, and lock wins over unlock.
- R9: While `wp_n` = 0, lock and unlock leave a locked-down block unchanged. While `wp_n` = 1, they move such a block to locked or unlocked.
- R10: Lock requests are ignored while the mode is reset or deep power-down.
- R11: `op_start` sets `op_busy` only in active mode with `vpp_ok` = 1. A later fall of `vpp_ok` leaves `op_busy` set, and `op_done` clears it. Outside active mode, for example in deep power-down, a start is rejected.
- R12: `sync_req` in active mode sets `read_sync` to 1. It stays at 1 until a reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| rst_pin_n | input | 1 | Device hardware reset pin, active low |
| ce_n | input | 1 | Chip enable, active low |
| le_n | input | 1 | Latch enable, active low |
| wp_n | input | 1 | Write protect; 0 freezes locked-down blocks |
| dpd_pin | input | 1 | Deep power-down pin, polarity set by `cfg_dpd_pol` |
| cfg_dpd_en | input | 1 | Permits deep power-down entry |
| cfg_dpd_pol | input | 1 | Power-down pin polarity, 1 = active high |
| vpp_ok | input | 1 | Program voltage valid |
| op_start | input | 1 | Program/erase start request |
| op_done | input | 1 | Program/erase completion |
| sync_req | input | 1 | Switch to synchronous read |
| lock_req | input | 1 | Lock block `blk_idx` |
| unlock_req | input | 1 | Unlock block `blk_idx` |
| lockdown_req | input | 1 | Lock down block `blk_idx` |
| blk_idx | input | $clog2(NBLK) | Target block |
| mode | output | 2 | Current mode code |
| data_valid | output | 1 | Read data may be driven |
| op_busy | output | 1 | Program/erase in progress |
| read_sync | output | 1 | Synchronous read selected |
| lock_state | output | 2*NBLK | Two bits per block, block i at [2i+1:2i] |

## Verification
Some rules can be checked on every cycle, and assertions do that. They check that the reset pin forces reset mode with all blocks locked, that `data_valid` never shows outside active mode, and that power-down is entered only from standby with the enable set. They also check that lock state stays frozen in deep power-down and that a start outside active mode never sets `op_busy`. Other behaviour needs ordered stimulus, and only the bench scenarios can show it. That covers the edge needed before data is valid, the polarity swap, lock-down under both write-protect levels, request priority, and a voltage drop during a busy operation.

// File: rtl/fpp_pkg.sv
package fpp_pkg;

    typedef enum logic [1:0] {
        MODE_RESET   = 2'd0,
        MODE_STANDBY = 2'd1,
        MODE_ACTIVE  = 2'd2,
        MODE_DPD     = 2'd3
    } mode_e;

    typedef enum logic [1:0] {
        LK_OPEN   = 2'd0,
        LK_LOCKED = 2'd1,
        LK_FROZEN = 2'd2
    } lock_e;

    typedef enum logic [1:0] {
        CMD_NONE,
        CMD_UNLOCK,
        CMD_LOCK,
        CMD_FREEZE
    } lock_cmd_e;

    typedef struct packed {
        logic rst_n;
        logic ce_n;
        logic le_n;
        logic dpd_on;
        logic dpd_en;
    } pin_bundle_t;

    // Freeze outranks lock, lock outranks unlock.
    function automatic lock_cmd_e pick_cmd(input logic lk, input logic ul, input logic fz);
        if (fz)      return CMD_FREEZE;
        else if (lk) return CMD_LOCK;
        else if (ul) return CMD_UNLOCK;
        else         return CMD_NONE;
    endfunction

    function automatic logic gates_locks(input mode_e m);
        return (m == MODE_STANDBY) || (m == MODE_ACTIVE);
    endfunction

endpackage

// File: rtl/fpp_mode_fsm.sv
module fpp_mode_fsm
    import fpp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pin_bundle_t pins,
    output mode_e       mode_q
);
    mode_e mode_d;

    always_comb begin
        mode_d = mode_q;
        if (!pins.rst_n) begin
            mode_d = MODE_RESET;
        end else if (mode_q == MODE_DPD) begin
            mode_d = pins.dpd_on ? MODE_DPD : MODE_STANDBY;
        end else if (pins.ce_n) begin
            if (mode_q == MODE_STANDBY && pins.dpd_en && pins.dpd_on)
                mode_d = MODE_DPD;
            else
                mode_d = MODE_STANDBY;
        end else begin
            mode_d = MODE_ACTIVE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) mode_q <= MODE_RESET;
        else     mode_q <= mode_d;
    end
endmodule

// File: rtl/fpp_read_qual.sv
module fpp_read_qual
    import fpp_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  pin_bundle_t pins,
    input  mode_e       mode_q,
    input  logic        sync_req,
    output logic        armed_q,
    output logic        sync_q
);
    logic ce_prev, le_prev, fall_seen;

    assign fall_seen = (ce_prev && !pins.ce_n) || (le_prev && !pins.le_n);

    always_ff @(posedge clk) begin
        if (rst) begin
            ce_prev <= 1'b1;
            le_prev <= 1'b1;
            armed_q <= 1'b0;
            sync_q  <= 1'b0;
        end else begin
            ce_prev <= pins.ce_n;
            le_prev <= pins.le_n;
            if (!pins.rst_n) begin
                armed_q <= 1'b0;
                sync_q  <= 1'b0;
            end else begin
                if (fall_seen) armed_q <= 1'b1;
                if (sync_req && mode_q == MODE_ACTIVE) sync_q <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/fpp_op_track.sv
module fpp_op_track
    import fpp_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  rst_pin_n,
    input  mode_e mode_q,
    input  logic  vpp_ok,
    input  logic  op_start,
    input  logic  op_done,
    output logic  busy_q
);
    always_ff @(posedge clk) begin
        if (rst || !rst_pin_n) begin
            busy_q <= 1'b0;
        end else if (busy_q) begin
            if (op_done) busy_q <= 1'b0;
        end else if (op_start && vpp_ok && mode_q == MODE_ACTIVE) begin
            busy_q <= 1'b1;
        end
    end
endmodule

// File: rtl/fpp_lock_array.sv
module fpp_lock_array
    import fpp_pkg::*;
#(
    parameter int NBLK = 8,
    localparam int IW  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_pin_n,
    input  logic              accept,
    input  lock_cmd_e         cmd,
    input  logic [IW-1:0]     idx,
    input  logic              wp_n,
    output logic [2*NBLK-1:0] state_vec
);
    for (genvar b = 0; b < NBLK; b++) begin : g_blk
        lock_e st;
        logic  hit, frozen_hold;

        assign hit         = accept && (idx == IW'(b));
        assign frozen_hold = (st == LK_FROZEN) && !wp_n;

        always_ff @(posedge clk) begin
            if (rst || !rst_pin_n) begin
                st <= LK_LOCKED;
            end else if (hit) begin
                case (cmd)
                    CMD_FREEZE: st <= LK_FROZEN;
                    CMD_LOCK:   if (!frozen_hold) st <= LK_LOCKED;
                    CMD_UNLOCK: if (!frozen_hold) st <= LK_OPEN;
                    default:    st <= st;
                endcase
            end
        end

        assign state_vec[2*b +: 2] = st;
    end
endmodule

// File: rtl/flash_pwr_prot_ctrl.sv
module flash_pwr_prot_ctrl
    import fpp_pkg::*;
#(
    parameter int NBLK = 8,
    localparam int IW  = (NBLK > 1) ? $clog2(NBLK) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rst_pin_n,
    input  logic              ce_n,
    input  logic              le_n,
    input  logic              wp_n,
    input  logic              dpd_pin,
    input  logic              cfg_dpd_en,
    input  logic              cfg_dpd_pol,
    input  logic              vpp_ok,
    input  logic              op_start,
    input  logic              op_done,
    input  logic              sync_req,
    input  logic              lock_req,
    input  logic              unlock_req,
    input  logic              lockdown_req,
    input  logic [IW-1:0]     blk_idx,
    output logic [1:0]        mode,
    output logic              data_valid,
    output logic              op_busy,
    output logic              read_sync,
    output logic [2*NBLK-1:0] lock_state
);
    pin_bundle_t pins;
    mode_e       mode_q;
    logic        armed_q;
    lock_cmd_e   cmd;
    logic        lk_accept;

    assign pins.rst_n  = rst_pin_n;
    assign pins.ce_n   = ce_n;
    assign pins.le_n   = le_n;
    assign pins.dpd_on = (dpd_pin == cfg_dpd_pol);
    assign pins.dpd_en = cfg_dpd_en;

    assign cmd       = pick_cmd(lock_req, unlock_req, lockdown_req);
    assign lk_accept = rst_pin_n && gates_locks(mode_q) && (cmd != CMD_NONE);

    fpp_mode_fsm u_mode (
        .clk(clk), .rst(rst), .pins(pins), .mode_q(mode_q)
    );

    fpp_read_qual u_rdq (
        .clk(clk), .rst(rst), .pins(pins), .mode_q(mode_q),
        .sync_req(sync_req), .armed_q(armed_q), .sync_q(read_sync)
    );

    fpp_op_track u_op (
        .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .mode_q(mode_q),
        .vpp_ok(vpp_ok), .op_start(op_start), .op_done(op_done), .busy_q(op_busy)
    );

    fpp_lock_array #(.NBLK(NBLK)) u_lk (
        .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .accept(lk_accept),
        .cmd(cmd), .idx(blk_idx), .wp_n(wp_n), .state_vec(lock_state)
    );

    assign mode       = mode_q;
    assign data_valid = armed_q && (mode_q == MODE_ACTIVE);
endmodule

// File: rtl/fpp_checker.sv
module fpp_checker #(
    parameter int NBLK = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              rst_pin_n,
    input logic              cfg_dpd_en,
    input logic [1:0]        mode,
    input logic              data_valid,
    input logic              op_busy,
    input logic              read_sync,
    input logic [2*NBLK-1:0] lock_state
);
    localparam logic [2*NBLK-1:0] ALL_LOCKED = {NBLK{2'b01}};

    // R1
    reset_mode_chk: assert property (@(posedge clk) disable iff (rst)
        !rst_pin_n |=> (mode == 2'd0) && !data_valid);

    // R2
    reset_locks_chk: assert property (@(posedge clk) disable iff (rst)
        !rst_pin_n |=> (lock_state == ALL_LOCKED) && !op_busy && !read_sync);

    // R3
    valid_active_chk: assert property (@(posedge clk) disable iff (rst)
        data_valid |-> mode == 2'd2);

    // R5
    dpd_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'd3) |=> (mode != 2'd3) || ($past(mode) == 2'd1 && $past(cfg_dpd_en)));

    // R10
    dpd_lock_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3 && rst_pin_n) |=> $stable(lock_state));

    // R11
    no_start_idle_chk: assert property (@(posedge clk) disable iff (rst)
        (mode != 2'd2 && !op_busy) |=> !op_busy);
endmodule

bind flash_pwr_prot_ctrl fpp_checker #(.NBLK(NBLK)) u_fpp_chk (
    .clk(clk), .rst(rst), .rst_pin_n(rst_pin_n), .cfg_dpd_en(cfg_dpd_en),
    .mode(mode), .data_valid(data_valid), .op_busy(op_busy),
    .read_sync(read_sync), .lock_state(lock_state)
);

// File: tb/tb_flash_pwr_prot_ctrl.sv
module tb_flash_pwr_prot_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NBLK = 8;
    localparam int IW = $clog2(NBLK);

    logic clk = 0;
    logic rst = 1, rst_pin_n = 0, ce_n = 1, le_n = 1, wp_n = 1, dpd_pin = 1;
    logic cfg_dpd_en = 0, cfg_dpd_pol = 0, vpp_ok = 0, op_start = 0, op_done = 0;
    logic sync_req = 0, lock_req = 0, unlock_req = 0, lockdown_req = 0;
    logic [IW-1:0] blk_idx = '0;
    logic [1:0] mode;
    logic data_valid, op_busy, read_sync;
    logic [2*NBLK-1:0] lock_state;

    int tests = 0, fails = 0, cyc = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    flash_pwr_prot_ctrl #(.NBLK(NBLK)) dut (.*);

    // Behavioural reference model
    int m_mode, m_lock[NBLK];
    bit m_armed, m_busy, m_sync, m_pce, m_ple;

    always @(posedge clk) begin
        int nm;
        bit fall, on, gate;
        int c;
        if (rst) begin
            m_mode = 0; m_armed = 0; m_busy = 0; m_sync = 0; m_pce = 1; m_ple = 1;
            foreach (m_lock[i]) m_lock[i] = 1;
        end else begin
            fall = (m_pce && !ce_n) || (m_ple && !le_n);
            on = (dpd_pin == cfg_dpd_pol);
            if (!rst_pin_n) nm = 0;
            else if (m_mode == 3) nm = on ? 3 : 1;
            else if (ce_n) nm = (m_mode == 1 && cfg_dpd_en && on) ? 3 : 1;
            else nm = 2;
            gate = rst_pin_n && (m_mode == 1 || m_mode == 2);
            if (!rst_pin_n) foreach (m_lock[i]) m_lock[i] = 1;
            else if (gate) begin
                c = lockdown_req ? 3 : lock_req ? 2 : unlock_req ? 1 : 0;
                if (c == 3) m_lock[blk_idx] = 2;
                else if (c != 0 && !(m_lock[blk_idx] == 2 && !wp_n))
                    m_lock[blk_idx] = (c == 2) ? 1 : 0;
            end
            if (!rst_pin_n) begin m_armed = 0; m_sync = 0; m_busy = 0; end
            else begin
                if (fall) m_armed = 1;
                if (sync_req && m_mode == 2) m_sync = 1;
                if (m_busy) begin if (op_done) m_busy = 0; end
                else if (op_start && vpp_ok && m_mode == 2) m_busy = 1;
            end
            m_pce = ce_n; m_ple = le_n; m_mode = nm;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst && !finished) begin
            chk("R1/R4 mode vs model", mode, m_mode);
            chk("R3 data_valid vs model", data_valid, (m_armed && m_mode == 2));
            chk("R11 op_busy vs model", op_busy, m_busy);
            chk("R12 read_sync vs model", read_sync, m_sync);
            for (int i = 0; i < NBLK; i++)
                chk("R8 lock vs model", lock_state[2*i +: 2], m_lock[i]);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 5000 && !finished) begin
            fails++; tests++;
            $display("FAIL watchdog: actual %0d expected <5000 cycles", cyc);
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    task automatic step(input int n = 1);
        for (int k = 0; k < n; k++) @(negedge clk);
        #1;
    endtask

    task automatic lk(input int idx, input bit l, input bit u, input bit d);
        blk_idx = IW'(idx); lock_req = l; unlock_req = u; lockdown_req = d;
        step();
        lock_req = 0; unlock_req = 0; lockdown_req = 0;
    endtask

    function automatic int blk(input int i);
        return lock_state[2*i +: 2];
    endfunction

    initial begin
        step(3);
        rst = 0;
        step(2);
        chk("R1 reset mode", mode, 0);
        chk("R1 no valid in reset", data_valid, 0);
        chk("R2 locked after reset", lock_state, {NBLK{2'b01}});
        lk(1, 0, 1, 0);
        chk("R10 unlock ignored in reset", blk(1), 1);

        rst_pin_n = 1; step();
        chk("R4 standby", mode, 1);
        ce_n = 0; step();
        chk("R4 active", mode, 2);
        chk("R3 valid after ce fall", data_valid, 1);

        rst_pin_n = 0; step(2);
        chk("R3 cleared by reset", data_valid, 0);
        rst_pin_n = 1; step();
        chk("R3 no edge yet", data_valid, 0);
        le_n = 0; step();
        chk("R3 valid after le fall", data_valid, 1);
        le_n = 1;

        lk(2, 0, 1, 0);
        chk("R8 unlock", blk(2), 0);
        lk(3, 1, 1, 1);
        chk("R8 lockdown wins", blk(3), 2);
        lk(2, 1, 1, 0);
        chk("R8 lock over unlock", blk(2), 1);
        wp_n = 0; lk(3, 0, 1, 0);
        chk("R9 frozen under wp low", blk(3), 2);
        wp_n = 1; lk(3, 0, 1, 0);
        chk("R9 unlock with wp high", blk(3), 0);

        ce_n = 1; step();
        dpd_pin = 0; cfg_dpd_en = 0; step(2);
        chk("R5 no dpd when disabled", mode, 1);
        cfg_dpd_en = 1; step();
        chk("R5 dpd entered", mode, 3);
        ce_n = 0; vpp_ok = 1; op_start = 1; step(); op_start = 0;
        chk("R7 dpd holds with ce low", mode, 3);
        chk("R11 start rejected in dpd", op_busy, 0);
        lk(4, 0, 1, 0);
        chk("R10 lock ignored in dpd", blk(4), 1);
        dpd_pin = 1; step();
        chk("R7 dpd exit to standby", mode, 1);
        step();
        chk("R4 active after exit", mode, 2);

        ce_n = 1; cfg_dpd_pol = 1; step();
        chk("R6 pin high not asserted yet", mode, 1);
        step();
        chk("R6 active-high dpd", mode, 3);
        dpd_pin = 0; step();
        chk("R6 deassert exits", mode, 1);
        cfg_dpd_pol = 0; dpd_pin = 1; ce_n = 0; step();

        vpp_ok = 0; op_start = 1; step(); op_start = 0;
        chk("R11 no start without vpp", op_busy, 0);
        vpp_ok = 1; op_start = 1; step(); op_start = 0;
        chk("R11 start accepted", op_busy, 1);
        vpp_ok = 0; step(2);
        chk("R11 vpp drop ignored", op_busy, 1);
        op_done = 1; step(); op_done = 0;
        chk("R11 done clears", op_busy, 0);

        sync_req = 1; step(); sync_req = 0;
        chk("R12 sync set", read_sync, 1);
        vpp_ok = 1; op_start = 1; step(); op_start = 0;
        rst_pin_n = 0; step();
        chk("R12 sync cleared by reset", read_sync, 0);
        chk("R2 busy cleared", op_busy, 0);
        chk("R2 locks restored", lock_state, {NBLK{2'b01}});
        rst_pin_n = 1; step(3);

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule